// File: doc/BRIEF.md
# Per-Core Activity Counter Bank

This block holds the event counters a processor core keeps for system management software. A fixed group of four 64-bit counters tracks core clock cycles, constant-rate system ticks, retired instructions and cycles in which dispatch is held up by a last-level-cache miss. A second group of up to sixteen 64-bit counters follows platform event pulses. Every counter has its own enable bit. While the core sits in a low-power wait state, no counter moves.

Software reaches the counters through a single request port. Each request carries a group select, a 4-bit index, a write flag, write data and the requester's privilege level. Requests from the lowest privilege level are refused unless the user-access enable is set. Higher-privilege writes load a full 64-bit value, which lets firmware put counts back after a power-off state. The response is registered and appears one cycle after the request.

Top module: `act_mon_bank`

## Requirements
- R1: A synchronous reset clears every counter to zero and drives `rsp_valid`, `rsp_fault` and `rsp_data` low.
- R2: Fixed index 0 advances by one on every clock cycle. Fixed index 1 advances by one on each cycle in which `sys_tick` is high.
- R3: Fixed index 2 advances by one on each cycle in which `ev_retire` is high. Fixed index 3 advances by one on each cycle in which `ev_llc_stall` is high.
- R4: While `core_wait` is high, no counter in either group changes, except through a write.
- R5: Fixed indices 4 to 15, and auxiliary indices at or above `NUM_AUX`, read as zero. Writes to them have no effect.
- R6: Auxiliary counter n (`req_group`=1, index n) advances by one on each cycle in which `aux_ev[n]` is high.
- R7: A counter whose enable bit is clear does not advance, and a read of it returns zero.
- R8: A request with `req_priv`=0 while `user_acc_en` is low sets `rsp_fault`, returns zero data and leaves every counter unchanged. Levels 1 to 3 are never refused.
- R9: A granted write loads all 64 bits of the addressed counter, whether or not the counter is enabled. If an event for that counter arrives in the same cycle, the written value wins.
- R10: A counter holding all ones that takes an event wraps to zero.
- R11: Every request produces `rsp_valid` exactly one cycle later. A read returns the counter value from the request cycle, before any update made in that cycle. Writes return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high cold reset |
| core_wait | input | 1 | Core is in a wait-for-interrupt or wait-for-event state |
| sys_tick | input | 1 | Constant-rate system tick strobe, already synchronised to clk |
| ev_retire | input | 1 | One instruction retired this cycle |
| ev_llc_stall | input | 1 | Dispatch is stalled by a last-level-cache miss this cycle |
| aux_ev | input | NUM_AUX | Platform event pulses, one per auxiliary counter |
| fix_en | input | 4 | Enable bits of the fixed counters |
| aux_en | input | NUM_AUX | Enable bits of the auxiliary counters |
| user_acc_en | input | 1 | Permits access from privilege level 0 |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_group | input | 1 | 0 = fixed group, 1 = auxiliary group |
| req_index | input | 4 | Counter index within the group |
| req_priv | input | 2 | Privilege level of the requester, 0 lowest |
| req_wdata | input | 64 | Value to load on a write |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_fault | output | 1 | The request was refused for privilege |
| rsp_data | output | 64 | Read data |

## Verification
All three response outputs come from one register stage, so each result is due exactly one clock after its request. The bench model therefore computes the expected response from its own counter state before it applies that cycle's update, and compares on the falling edge after the next rising edge. Counter effects (events, freezes, loads) show up in the read issued on the following cycle. The model advances its counters in step with each rising edge, so every read is checked against a value that already includes all earlier events.

// File: rtl/act_mon_pkg.sv
package act_mon_pkg;
  localparam int CNT_W     = 64;
  localparam int FIX_N     = 4;
  localparam int IDX_W     = 4;
  localparam int MAX_AUX   = 16;
  localparam int PRIV_W    = 2;
  localparam logic [PRIV_W-1:0] PRIV_USER = '0;

  typedef enum logic [1:0] {
    FIX_CYCLES = 2'd0,
    FIX_TICKS  = 2'd1,
    FIX_RETIRE = 2'd2,
    FIX_STALL  = 2'd3
  } fix_slot_e;
endpackage

// File: rtl/act_mon_counter.sv
module act_mon_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         freeze,
  input  logic         evt,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt
);
  logic bump;
  assign bump = en && !freeze && evt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (bump) cnt <= cnt + 1'b1;
  end

  a_r4_freeze_holds: assert property (@(posedge clk) disable iff (rst)
    (freeze && !ld) |=> $stable(cnt));
  a_r7_disabled_holds: assert property (@(posedge clk) disable iff (rst)
    (!en && !ld) |=> $stable(cnt));
  a_r9_load_wins: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cnt == $past(ld_val)));
  a_r10_wraps: assert property (@(posedge clk) disable iff (rst)
    (bump && !ld && (cnt == {W{1'b1}})) |=> (cnt == '0));
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cnt == '0));
endmodule

// File: rtl/act_mon_gate.sv
module act_mon_gate
  import act_mon_pkg::*;
#(
  parameter int NUM_AUX = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_group,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [PRIV_W-1:0] req_priv,
  input  logic              user_acc_en,
  output logic              fault,
  output logic              read_ok,
  output logic [FIX_N-1:0]  wr_fix,
  output logic [NUM_AUX-1:0] wr_aux
);
  logic granted;
  logic wr_go;

  assign fault   = req_valid && (req_priv == PRIV_USER) && !user_acc_en;
  assign granted = req_valid && !fault;
  assign read_ok = granted && !req_write;
  assign wr_go   = granted && req_write;

  for (genvar i = 0; i < FIX_N; i++) begin : g_fix_wr
    assign wr_fix[i] = wr_go && !req_group && (req_index == IDX_W'(i));
  end
  for (genvar j = 0; j < NUM_AUX; j++) begin : g_aux_wr
    assign wr_aux[j] = wr_go && req_group && (req_index == IDX_W'(j));
  end

  a_r8_no_write_when_trapped: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_priv == PRIV_USER) && !user_acc_en) |-> (wr_fix == '0 && wr_aux == '0));
  a_r8_one_write_target: assert property (@(posedge clk) disable iff (rst)
    $countones({wr_fix, wr_aux}) <= 1);
endmodule

// File: rtl/act_mon_bank.sv
module act_mon_bank
  import act_mon_pkg::*;
#(
  parameter int NUM_AUX = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               core_wait,
  input  logic               sys_tick,
  input  logic               ev_retire,
  input  logic               ev_llc_stall,
  input  logic [NUM_AUX-1:0] aux_ev,
  input  logic [FIX_N-1:0]   fix_en,
  input  logic [NUM_AUX-1:0] aux_en,
  input  logic               user_acc_en,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_group,
  input  logic [IDX_W-1:0]   req_index,
  input  logic [PRIV_W-1:0]  req_priv,
  input  logic [CNT_W-1:0]   req_wdata,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [CNT_W-1:0]   rsp_data
);
  logic [CNT_W-1:0]   fix_cnt [FIX_N];
  logic [CNT_W-1:0]   aux_cnt [NUM_AUX];
  logic [FIX_N-1:0]   fix_evt;
  logic [FIX_N-1:0]   wr_fix;
  logic [NUM_AUX-1:0] wr_aux;
  logic               fault, read_ok;
  logic [CNT_W-1:0]   sel_val;

  always_comb begin
    fix_evt             = '0;
    fix_evt[FIX_CYCLES] = 1'b1;
    fix_evt[FIX_TICKS]  = sys_tick;
    fix_evt[FIX_RETIRE] = ev_retire;
    fix_evt[FIX_STALL]  = ev_llc_stall;
  end

  act_mon_gate #(.NUM_AUX(NUM_AUX)) u_gate (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_group(req_group),
    .req_index(req_index), .req_priv(req_priv), .user_acc_en(user_acc_en),
    .fault(fault), .read_ok(read_ok), .wr_fix(wr_fix), .wr_aux(wr_aux)
  );

  for (genvar i = 0; i < FIX_N; i++) begin : g_fix
    act_mon_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .en(fix_en[i]), .freeze(core_wait),
      .evt(fix_evt[i]), .ld(wr_fix[i]), .ld_val(req_wdata), .cnt(fix_cnt[i])
    );
  end

  for (genvar j = 0; j < NUM_AUX; j++) begin : g_aux
    act_mon_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .en(aux_en[j]), .freeze(core_wait),
      .evt(aux_ev[j]), .ld(wr_aux[j]), .ld_val(req_wdata), .cnt(aux_cnt[j])
    );
  end

  // Unimplemented or disabled slots contribute zero.
  always_comb begin
    sel_val = '0;
    if (!req_group) begin
      for (int i = 0; i < FIX_N; i++)
        if (req_index == IDX_W'(i) && fix_en[i]) sel_val = fix_cnt[i];
    end else begin
      for (int j = 0; j < NUM_AUX; j++)
        if (req_index == IDX_W'(j) && aux_en[j]) sel_val = aux_cnt[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= fault;
      rsp_data  <= read_ok ? sel_val : '0;
    end
  end

  a_r11_resp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r8_fault_no_data: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_data == '0));
  a_r5_fixed_hole_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_group && req_index >= IDX_W'(FIX_N)) |=> (rsp_data == '0));
  a_r1_outputs_clear: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !rsp_fault && rsp_data == '0));
endmodule

// File: tb/sim_act_mon_bank.sv
module sim_act_mon_bank;
  localparam int NA = 6;

  logic clk = 1'b0;
  logic rst;
  logic core_wait, sys_tick, ev_retire, ev_llc_stall;
  logic [NA-1:0] aux_ev, aux_en;
  logic [3:0] fix_en;
  logic user_acc_en, req_valid, req_write, req_group;
  logic [3:0] req_index;
  logic [1:0] req_priv;
  logic [63:0] req_wdata;
  logic rsp_valid, rsp_fault;
  logic [63:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  longint unsigned m_fix [4];
  longint unsigned m_aux [NA];
  bit e_valid, e_fault;
  longint unsigned e_data;
  string e_tag;

  always #4 clk = ~clk;

  act_mon_bank #(.NUM_AUX(NA)) u0 (
    .clk(clk), .rst(rst), .core_wait(core_wait), .sys_tick(sys_tick),
    .ev_retire(ev_retire), .ev_llc_stall(ev_llc_stall), .aux_ev(aux_ev),
    .fix_en(fix_en), .aux_en(aux_en), .user_acc_en(user_acc_en),
    .req_valid(req_valid), .req_write(req_write), .req_group(req_group),
    .req_index(req_index), .req_priv(req_priv), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_data(rsp_data)
  );

  task automatic chk(string tag, longint unsigned got, longint unsigned exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // Expected response from pre-edge state, then model update for this edge.
  task automatic model(string tag);
    bit trap, impl, en;
    longint unsigned val;
    if (rst) begin
      foreach (m_fix[i]) m_fix[i] = 0;
      foreach (m_aux[i]) m_aux[i] = 0;
      e_valid = 0; e_fault = 0; e_data = 0; e_tag = "R1";
      return;
    end
    trap = req_valid && req_priv == 0 && !user_acc_en;
    impl = req_group ? (req_index < NA) : (req_index < 4);
    en = 0; val = 0;
    if (impl) begin
      en  = req_group ? aux_en[req_index] : fix_en[req_index];
      val = req_group ? m_aux[req_index] : m_fix[req_index[1:0]];
    end
    e_valid = req_valid;
    e_fault = trap;
    e_data  = (req_valid && !req_write && !trap && en) ? val : 0;
    if (tag != "") e_tag = tag;
    else if (!req_valid) e_tag = "R11";
    else if (trap) e_tag = "R8";
    else if (!impl) e_tag = "R5";
    else if (!en) e_tag = "R7";
    else if (core_wait) e_tag = "R4";
    else if (req_group) e_tag = "R6";
    else if (req_index < 2) e_tag = "R2";
    else e_tag = "R3";
    for (int i = 0; i < 4; i++) begin
      bit ev;
      ev = (i == 0) ? 1'b1 : (i == 1) ? sys_tick : (i == 2) ? ev_retire : ev_llc_stall;
      if (req_valid && req_write && !trap && !req_group && req_index == i) m_fix[i] = req_wdata;
      else if (fix_en[i] && !core_wait && ev) m_fix[i] = m_fix[i] + 1;
    end
    for (int j = 0; j < NA; j++) begin
      if (req_valid && req_write && !trap && req_group && req_index == j) m_aux[j] = req_wdata;
      else if (aux_en[j] && !core_wait && aux_ev[j]) m_aux[j] = m_aux[j] + 1;
    end
  endtask

  task automatic step(string tag = "");
    model(tag);
    @(posedge clk);
    @(negedge clk);
    chk({e_tag, " valid"}, 64'(rsp_valid), 64'(e_valid));
    chk({e_tag, " fault"}, 64'(rsp_fault), 64'(e_fault));
    chk({e_tag, " data"}, rsp_data, e_data);
  endtask

  task automatic idle();
    core_wait = 0; sys_tick = 0; ev_retire = 0; ev_llc_stall = 0;
    aux_ev = '0; req_valid = 0; req_write = 0; req_group = 0;
    req_index = 0; req_priv = 3; req_wdata = 0;
  endtask

  task automatic req(bit wr, bit grp, int idx, int pv, longint unsigned wd);
    req_valid = 1; req_write = wr; req_group = grp;
    req_index = 4'(idx); req_priv = 2'(pv); req_wdata = wd;
  endtask

  task automatic rand_phase(int n, int p_wait, int p_user, int p_dis);
    for (int c = 0; c < n; c++) begin
      core_wait    = ($urandom % 100) < p_wait;
      sys_tick     = ($urandom % 4) == 0;
      ev_retire    = $urandom % 2;
      ev_llc_stall = ($urandom % 3) == 0;
      aux_ev       = NA'($urandom);
      if (($urandom % 20) == 0) begin
        fix_en = 4'($urandom) | 4'((p_dis == 0) ? 4'hF : 4'h0);
        aux_en = NA'($urandom) | ((p_dis == 0) ? {NA{1'b1}} : '0);
      end
      user_acc_en = ($urandom % 100) >= p_user;
      req_valid = ($urandom % 4) != 0;
      req_write = ($urandom % 8) == 0;
      req_group = $urandom % 2;
      req_index = (($urandom % 4) == 0) ? 4'($urandom) : 4'($urandom % 4);
      req_priv  = 2'($urandom);
      req_wdata = {$urandom, $urandom};
      step();
    end
  endtask

  initial begin
    idle();
    fix_en = 4'hF; aux_en = '1; user_acc_en = 1;
    rst = 1;
    step("R1");
    step("R1");
    chk("R1 valid after reset", 64'(rsp_valid), 0);
    rst = 0;
    // Fresh reads right after reset: ticks counter untouched.
    req(0, 0, 1, 3, 0); step("R1");
    req(0, 1, 2, 3, 0); step("R1");
    // Full 64-bit load, then read back.
    req(1, 0, 2, 2, 64'h1234_5678_9ABC_DEF0); step("R9");
    req(0, 0, 2, 2, 0); ev_retire = 1; step("R9");
    // Write collides with an event: written value wins.
    req(1, 0, 3, 1, 64'hA5A5_0000_0000_0001); ev_llc_stall = 1; step("R9");
    req(0, 0, 3, 1, 0); ev_llc_stall = 0; step("R9");
    // Wrap.
    req(1, 1, 0, 3, 64'hFFFF_FFFF_FFFF_FFFF); step("R10");
    aux_ev = NA'(1); req(0, 1, 0, 3, 0); step("R10");
    req(0, 1, 0, 3, 0); step("R10");
    // Freeze under wait.
    aux_ev = '0; core_wait = 1; ev_retire = 1; sys_tick = 1;
    req(0, 0, 0, 3, 0); step("R4");
    req(0, 0, 0, 3, 0); step("R4");
    core_wait = 0; sys_tick = 0; ev_retire = 0;
    // Trapped user write has no effect.
    user_acc_en = 0; req(1, 0, 1, 0, 64'hDEAD); step("R8");
    user_acc_en = 1; req(0, 0, 1, 0, 0); step("R8");
    // Unimplemented slots.
    req(1, 0, 9, 3, 64'h77); step("R5");
    req(0, 0, 9, 3, 0); step("R5");
    req(1, 1, NA, 3, 64'h55); step("R5");
    req(0, 1, NA, 3, 0); step("R5");
    // Disabled counter: loaded but reads zero and does not count.
    fix_en = 4'b1110; req(1, 0, 0, 3, 64'h40); step("R7");
    req(0, 0, 0, 3, 0); step("R7");
    fix_en = 4'hF; req(0, 0, 0, 3, 0); step("R7");
    req_valid = 0; step("R11");
    rand_phase(4000, 0, 0, 0);
    rand_phase(4000, 30, 20, 0);
    rand_phase(4000, 10, 40, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule